// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 32-bit unsigned operands and a one-bit carry input, and returns a 32-bit sum and a carry output. It is purely combinational and has no clock or reset. A result appears at the outputs after the gate delay of the adder, with no register stage in between.

The word is split into eight slices of four bits. Each slice does three things:
- It forms a per-bit generate term, the AND of the operand bits.
- It forms a per-bit propagate term, the OR of the operand bits.
- It reduces those eight terms to one slice generate and one slice propagate.

A short chain runs through the eight slices. It builds each slice's incoming carry from the previous slice's carry and that slice's reduced terms, so the carry never passes through the bit chain inside a slice. Within a slice, the sum bits are formed by XOR of the operand bits and the carry arriving at each bit position. Those carries come from the slice's incoming carry and its lower bits.

Top module: `cla_add32`

## Requirements
- R1: For every input, the concatenation {cout_o, sum_o} equals the 33-bit unsigned value a_i + b_i + cin_i.
- R2: With both operands zero and cin_i = 0, sum_o is 0 and cout_o is 0.
- R3: With a_i = 0xFFFF_FFFF, b_i = 0 and cin_i = 1, sum_o is 0 and cout_o is 1. The carry crosses all eight slice boundaries.
- R4: With both operands zero and cin_i = 1, sum_o is 0x0000_0001 and cout_o is 0.
- R5: With alternating operands a_i = 0x5555_5555, b_i = 0xAAAA_AAAA and cin_i = 1, sum_o is 0 and cout_o is 1. With cin_i = 0, sum_o is 0xFFFF_FFFF and cout_o is 0.
- R6: A carry produced in slice k reaches slice k+1. For each k from 0 to 6, a_i = 2^(4k+4) - 1 with b_i = 1 and cin_i = 0 yields sum_o = 2^(4k+4) and cout_o = 0.
- R7: cout_o is 1 exactly when a_i + b_i + cin_i is greater than 0xFFFF_FFFF.
- R8: Exchanging a_i and b_i leaves sum_o and cout_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand, unsigned |
| b_i | input | 32 | Second operand, unsigned |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 32 | Low 32 bits of the result |
| cout_o | output | 1 | Carry out of bit 31 |

## Verification
The bound checker tests the full 33-bit sum identity and the carry-out threshold whenever the inputs are known. It also tests the fixed results for the zero, all-ones and alternating operand patterns whenever those patterns are present.

Some behaviours only the bench scenarios can show:
- The carry handoff across each individual slice boundary, tested with targeted vectors.
- Insensitivity to operand order, which needs two applied vectors to compare.
- Broad coverage over random operands.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned SLICE_W = 4;

  typedef struct packed {
    logic gen;
    logic prop;
  } slice_pg_t;
endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] gen_o,
  output logic [W-1:0] prop_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen_o[i]  = a_i[i] & b_i[i];
    assign prop_o[i] = a_i[i] | b_i[i];
  end
endmodule

// File: rtl/cla_slice_reduce.sv
module cla_slice_reduce
  import cla_pkg::*;
#(
  parameter int unsigned W = SLICE_W
) (
  input  logic [W-1:0] gen_i,
  input  logic [W-1:0] prop_i,
  output slice_pg_t    pg_o
);
  logic g_acc;

  // nested form: g[top] | p[top] & (g[top-1] | p[top-1] & (...))
  always_comb begin
    g_acc = gen_i[0];
    for (int k = 1; k < W; k++) begin
      g_acc = gen_i[k] | (prop_i[k] & g_acc);
    end
  end

  assign pg_o.gen  = g_acc;
  assign pg_o.prop = &prop_i;
endmodule

// File: rtl/cla_slice_sum.sv
module cla_slice_sum #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] gen_i,
  input  logic [W-1:0] prop_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o
);
  logic [W:0] c_loc;

  assign c_loc[0] = cin_i;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign c_loc[i+1] = gen_i[i] | (prop_i[i] & c_loc[i]);
    // sum must use XOR; the OR-based propagate cannot form it
    assign sum_o[i]   = a_i[i] ^ b_i[i] ^ c_loc[i];
  end
endmodule

// File: rtl/cla_add32.sv
module cla_add32
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int unsigned NUM_SL = WIDTH / SLICE_W;

  logic [WIDTH-1:0] gen_w;
  logic [WIDTH-1:0] prop_w;
  slice_pg_t        sl_pg [NUM_SL];
  logic [NUM_SL:0]  sl_c;

  // step 1: per-bit terms
  cla_bit_pg #(.W(WIDTH)) u_pg (
    .a_i    (a_i),
    .b_i    (b_i),
    .gen_o  (gen_w),
    .prop_o (prop_w)
  );

  assign sl_c[0] = cin_i;

  for (genvar s = 0; s < NUM_SL; s++) begin : g_slice
    localparam int unsigned LO = s * SLICE_W;

    // step 2: slice terms
    cla_slice_reduce #(.W(SLICE_W)) u_red (
      .gen_i  (gen_w[LO +: SLICE_W]),
      .prop_i (prop_w[LO +: SLICE_W]),
      .pg_o   (sl_pg[s])
    );

    // step 3: slice-to-slice carry, bypassing internal bit chain
    assign sl_c[s+1] = sl_pg[s].gen | (sl_pg[s].prop & sl_c[s]);

    cla_slice_sum #(.W(SLICE_W)) u_sum (
      .a_i    (a_i[LO +: SLICE_W]),
      .b_i    (b_i[LO +: SLICE_W]),
      .gen_i  (gen_w[LO +: SLICE_W]),
      .prop_i (prop_w[LO +: SLICE_W]),
      .cin_i  (sl_c[s]),
      .sum_o  (sum_o[LO +: SLICE_W])
    );
  end

  assign cout_o = sl_c[NUM_SL];
endmodule

// File: rtl/cla_add32_chk.sv
module cla_add32_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o
);
  localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ALT5 = {(WIDTH/2){2'b01}};
  localparam logic [WIDTH-1:0] ALTA = {(WIDTH/2){2'b10}};

  logic [WIDTH:0] ref_w;
  logic           known_w;

  assign ref_w   = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
  assign known_w = !$isunknown({a_i, b_i, cin_i, sum_o, cout_o});

  always_comb begin
    if (known_w) begin
      p_sum_r1: assert ({cout_o, sum_o} == ref_w)
        else $error("R1 sum mismatch");
      p_cout_r7: assert (cout_o == (({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}) > {1'b0, ONES}))
        else $error("R7 carry-out threshold");
      if (a_i == '0 && b_i == '0)
        p_zero_r2: assert (!cout_o && sum_o == {{(WIDTH-1){1'b0}}, cin_i})
          else $error("R2 zero operands");
      if (a_i == ONES && b_i == '0 && cin_i)
        p_ones_r3: assert (cout_o && sum_o == '0)
          else $error("R3 all-ones plus one");
      if (a_i == ALT5 && b_i == ALTA)
        p_alt_r5: assert (cout_o == cin_i && sum_o == (cin_i ? '0 : ONES))
          else $error("R5 alternating operands");
    end
  end
endmodule

bind cla_add32 cla_add32_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .cin_i  (cin_i),
  .sum_o  (sum_o),
  .cout_o (cout_o)
);

// File: tb/tb_cla_add32.sv
module tb_cla_add32;
  localparam int unsigned WIDTH = 32;

  logic             clk;
  logic             rst_ni;
  logic [WIDTH-1:0] a_i;
  logic [WIDTH-1:0] b_i;
  logic             cin_i;
  logic [WIDTH-1:0] sum_o;
  logic             cout_o;

  int n_vec;
  int n_bad;
  bit done;

  cla_add32 #(.WIDTH(WIDTH)) dut (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .sum_o  (sum_o),
    .cout_o (cout_o)
  );

  initial clk = 1'b0;
  always #4ns clk = ~clk;

  // apply at posedge, compare at negedge against behavioural reference
  task automatic apply(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                       input logic c, input string req);
    longint unsigned exp_full;
    logic [WIDTH:0]  got;
    @(posedge clk);
    a_i   = a;
    b_i   = b;
    cin_i = c;
    @(negedge clk);
    exp_full = longint'(a) + longint'(b) + longint'(c);
    got      = {cout_o, sum_o};
    n_vec++;
    if (got !== exp_full[WIDTH:0]) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h cin=%0d actual=%h expected=%h",
               req, a, b, c, got, exp_full[WIDTH:0]);
    end
  endtask

  task automatic check_swap(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                            input logic c);
    logic [WIDTH:0] first;
    apply(a, b, c, "R8");
    first = {cout_o, sum_o};
    apply(b, a, c, "R8");
    n_vec++;
    if ({cout_o, sum_o} !== first) begin
      n_bad++;
      $display("FAIL R8 swap actual=%h expected=%h", {cout_o, sum_o}, first);
    end
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    n_vec  = 0;
    n_bad  = 0;
    done   = 1'b0;
    rst_ni = 1'b0;
    a_i    = '0;
    b_i    = '0;
    cin_i  = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // R2: reset-like idle state
    apply('0, '0, 1'b0, "R2");
    // R4
    apply('0, '0, 1'b1, "R4");
    // R3
    apply(32'hFFFF_FFFF, '0, 1'b1, "R3");
    apply(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R3");
    // R5
    apply(32'h5555_5555, 32'hAAAA_AAAA, 1'b1, "R5");
    apply(32'h5555_5555, 32'hAAAA_AAAA, 1'b0, "R5");
    // R6: handoff across each slice boundary
    for (int k = 0; k < 7; k++) begin
      apply((32'h1 << (4*k+4)) - 32'h1, 32'h1, 1'b0, "R6");
    end
    // R7: threshold edges
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R7");
    apply(32'h8000_0000, 32'h7FFF_FFFF, 1'b0, "R7");
    apply(32'h8000_0000, 32'h8000_0000, 1'b0, "R7");
    // R8
    check_swap(32'h1234_5678, 32'hF0F0_0F0F, 1'b1);
    check_swap(32'hDEAD_BEEF, 32'h0000_0001, 1'b0);
    // R1: random operands
    for (int i = 0; i < 2000; i++) begin
      apply($urandom, $urandom, 1'($urandom), "R1");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule